// File: doc/BRIEF.md
# Microprocessor Reset Supervisor Controller

This block produces the reset for a processor from three independent causes: a supply-good level delivered by an external comparator, a watchdog that the processor must strobe, and a push-button. Any active cause pulls the active-low reset output low at once and keeps it low while the cause remains. When the last cause clears, a single shared pulse generator holds the reset for a minimum width of `PULSE_TICKS` clock cycles before releasing it. An active-high copy of the reset is always the exact inverse of the active-low output. All time constants are parameters counted in clock ticks, so a bench can use short values.

The three level inputs (supply good, watchdog strobe, button) each pass through a two-flop synchronizer before any edge detection or counting is done. The watchdog is serviced only by a falling edge of the strobe. A strobe held steady at either level is treated as no service and times out. While the strobe stays unserviced, the watchdog fires again once every period, so the reset repeats. The watchdog period is chosen by a 2-bit select.

Three state machines do the work:
- **Pulse generator** (`PG_IDLE`, `PG_HOLD`, `PG_STRETCH`). It moves idle→hold on any request and hold→stretch when requests clear. It moves stretch→idle once the width counter reaches its last count, and stretch→hold on a new request, which reloads the width.
- **Watchdog** (`WD_PARKED`, `WD_RUN`). It moves parked→run when reset is released and run→parked while reset is active. In run, a strobe fall clears the count, and reaching the limit emits a one-cycle expiry.
- **Button debouncer** (`BT_RELEASED`, `BT_COUNTING`, `BT_PRESSED`). It moves released→counting on a low sample and counting→pressed after `PB_TICKS` consecutive low samples. It moves counting→released or pressed→released on a high sample.

Top module: `rst_supervisor`

## Requirements
- R1: While `arst_n` is low, `rst_n` is 0 and `rst` is 1.
- R2: When `supply_ok` goes low, `rst_n` goes low within 4 clock cycles and stays low as long as `supply_ok` is low.
- R3: After every reset cause has cleared, `rst_n` stays low for at least `PULSE_TICKS` cycles and goes high no more than `PULSE_TICKS`+6 cycles after the input that cleared the cause.
- R4: Only a high-to-low transition of `wd_strobe` restarts the watchdog count. A strobe held at 0 or held at 1 lets the watchdog expire, which asserts reset.
- R5: While the strobe stays unserviced, a new reset pulse is produced after every watchdog period that follows each release.
- R6: The period is selected by `wd_sel`: 0 gives `WD_SHORT` cycles, 1 gives `WD_MED` cycles, and 2 or 3 give `WD_LONG` cycles, each measured from the last serviced edge.
- R7: A low level on `pb_n` lasting fewer than `PB_TICKS` cycles is ignored, and `rst_n` stays high.
- R8: A low level on `pb_n` lasting at least `PB_TICKS` cycles asserts reset. Reset then stays low while the button is held and for the R3 width after release.
- R9: `rst` equals the inverse of `rst_n` at every cycle.
- R10: A new request arriving during the minimum-width pulse reloads it, so the width is counted from the end of the last request.
- R11: The watchdog count is held at zero while reset is active and starts from zero when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Supply-good level from the external comparator |
| wd_strobe | input | 1 | Watchdog service strobe; a falling edge services it |
| wd_sel | input | 2 | Watchdog period select: 0 short, 1 medium, 2 or 3 long |
| pb_n | input | 1 | Push-button, active low |
| rst_n | output | 1 | Processor reset, active low |
| rst | output | 1 | Processor reset, active high |

## Verification
On every cycle, the assertions check the state-machine rules:
- A request forces the hold state on the next cycle.
- The stretch never ends before its last count.
- The watchdog count is zeroed while in reset and stays below the long limit.
- No expiry is raised in a cycle that followed reset.
- A confirmed press leaves only through release.

Only the bench scenarios can show end-to-end timing at the ports, with sampling windows around each expected edge. These scenarios cover the pulse width after power, supply dips and button release; the reload during a running pulse; timeout from each held strobe level; repeated pulses under starvation; each select value; and the rejection of short button presses.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

    typedef enum logic [1:0] {
        PG_IDLE    = 2'd0,
        PG_HOLD    = 2'd1,
        PG_STRETCH = 2'd2
    } pgen_state_t;

    typedef enum logic {
        WD_PARKED = 1'b0,
        WD_RUN    = 1'b1
    } wdog_state_t;

    typedef enum logic [1:0] {
        BT_RELEASED = 2'd0,
        BT_COUNTING = 2'd1,
        BT_PRESSED  = 2'd2
    } btn_state_t;

endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
    parameter int              WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                stage1[b] <= RST_VAL[b];
                stage2[b] <= RST_VAL[b];
            end else begin
                stage1[b] <= d_in[b];
                stage2[b] <= stage1[b];
            end
        end
    end

    assign q_out = stage2;
endmodule

// File: rtl/rstsup_pulse_gen.sv
module rstsup_pulse_gen
    import rstsup_pkg::*;
#(
    parameter int PULSE_TICKS = 12_500_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic req,
    output logic in_reset
);
    localparam int CW = $clog2(PULSE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

    pgen_state_t state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            PG_IDLE: begin
                if (req) state_nx = PG_HOLD;
            end
            PG_HOLD: begin
                if (!req) begin
                    state_nx = PG_STRETCH;
                    cnt_nx   = '0;
                end
            end
            PG_STRETCH: begin
                if (req) begin
                    state_nx = PG_HOLD;
                end else if (cnt == LAST) begin
                    state_nx = PG_IDLE;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            default: state_nx = PG_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state <= PG_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        in_reset = (state != PG_IDLE);
    end

    // R10: any request parks the generator in hold on the next cycle
    assert_req_forces_hold_R10: assert property (@(posedge clk) disable iff (!arst_n)
        req |=> (state == PG_HOLD));

    // R3: the stretch cannot end before its last count
    assert_stretch_full_width_R3: assert property (@(posedge clk) disable iff (!arst_n)
        (state == PG_STRETCH && cnt != LAST) |=> (state != PG_IDLE));
endmodule

// File: rtl/rstsup_watchdog.sv
module rstsup_watchdog
    import rstsup_pkg::*;
#(
    parameter int WD_SHORT = 3_125_000,
    parameter int WD_MED   = 12_500_000,
    parameter int WD_LONG  = 30_000_000
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       strobe_q,
    input  logic [1:0] sel,
    input  logic       in_reset,
    output logic       expire
);
    localparam int CW = $clog2(WD_LONG + 1);

    wdog_state_t state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [CW-1:0] limit_m1;
    logic          strobe_prev;
    logic          strobe_fall;
    logic          expire_nx;

    always_comb begin
        unique case (sel)
            2'd0:    limit_m1 = CW'(WD_SHORT - 1);
            2'd1:    limit_m1 = CW'(WD_MED - 1);
            default: limit_m1 = CW'(WD_LONG - 1);
        endcase
    end

    assign strobe_fall = strobe_prev & ~strobe_q;

    always_comb begin
        state_nx  = state;
        cnt_nx    = cnt;
        expire_nx = 1'b0;
        unique case (state)
            WD_PARKED: begin
                cnt_nx = '0;
                if (!in_reset) state_nx = WD_RUN;
            end
            WD_RUN: begin
                if (in_reset) begin
                    state_nx = WD_PARKED;
                    cnt_nx   = '0;
                end else if (strobe_fall) begin
                    cnt_nx = '0;
                end else if (cnt >= limit_m1) begin
                    cnt_nx    = '0;
                    expire_nx = 1'b1;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            default: state_nx = WD_PARKED;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state       <= WD_PARKED;
            cnt         <= '0;
            strobe_prev <= 1'b0;
            expire      <= 1'b0;
        end else begin
            state       <= state_nx;
            cnt         <= cnt_nx;
            strobe_prev <= strobe_q;
            expire      <= expire_nx;
        end
    end

    // R11: count is zero one cycle after any cycle spent in reset
    assert_cnt_cleared_in_reset_R11: assert property (@(posedge clk) disable iff (!arst_n)
        in_reset |=> (cnt == '0));

    // R11: no expiry follows a cycle in reset
    assert_no_expire_after_reset_R11: assert property (@(posedge clk) disable iff (!arst_n)
        expire |-> !$past(in_reset));

    // R6: the count never reaches the longest period
    assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!arst_n)
        cnt < CW'(WD_LONG));
endmodule

// File: rtl/rstsup_button.sv
module rstsup_button
    import rstsup_pkg::*;
#(
    parameter int PB_TICKS = 2_000_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic btn_low,
    output logic pb_req
);
    localparam int CW = $clog2(PB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(PB_TICKS - 1);

    btn_state_t state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            BT_RELEASED: begin
                if (btn_low) begin
                    state_nx = BT_COUNTING;
                    cnt_nx   = CW'(1);
                end
            end
            BT_COUNTING: begin
                if (!btn_low) begin
                    state_nx = BT_RELEASED;
                    cnt_nx   = '0;
                end else if (cnt == LAST) begin
                    state_nx = BT_PRESSED;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            BT_PRESSED: begin
                if (!btn_low) begin
                    state_nx = BT_RELEASED;
                    cnt_nx   = '0;
                end
            end
            default: state_nx = BT_RELEASED;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state <= BT_RELEASED;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        pb_req = (state == BT_PRESSED);
    end

    // R8: a confirmed press leaves only through release
    assert_press_exits_to_release_R8: assert property (@(posedge clk) disable iff (!arst_n)
        (state == BT_PRESSED) |=> (state == BT_PRESSED || state == BT_RELEASED));

    // R7: the debounce count stays below its limit
    assert_debounce_bounded_R7: assert property (@(posedge clk) disable iff (!arst_n)
        cnt < CW'(PB_TICKS));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int PULSE_TICKS = 12_500_000,
    parameter int PB_TICKS    = 2_000_000,
    parameter int WD_SHORT    = 3_125_000,
    parameter int WD_MED      = 12_500_000,
    parameter int WD_LONG     = 30_000_000
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       supply_ok,
    input  logic       wd_strobe,
    input  logic [1:0] wd_sel,
    input  logic       pb_n,
    output logic       rst_n,
    output logic       rst
);
    localparam int NSYNC = 3;
    localparam logic [NSYNC-1:0] SYNC_RST = 3'b100;

    logic [NSYNC-1:0] sync_q;
    logic supply_q, strobe_q, pb_q;
    logic wd_expire, pb_req, req, in_reset;

    rstsup_sync #(.WIDTH(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_in   ({pb_n, wd_strobe, supply_ok}),
        .q_out  (sync_q)
    );

    assign supply_q = sync_q[0];
    assign strobe_q = sync_q[1];
    assign pb_q     = sync_q[2];

    rstsup_watchdog #(.WD_SHORT(WD_SHORT), .WD_MED(WD_MED), .WD_LONG(WD_LONG)) u_wdog (
        .clk      (clk),
        .arst_n   (arst_n),
        .strobe_q (strobe_q),
        .sel      (wd_sel),
        .in_reset (in_reset),
        .expire   (wd_expire)
    );

    rstsup_button #(.PB_TICKS(PB_TICKS)) u_btn (
        .clk     (clk),
        .arst_n  (arst_n),
        .btn_low (~pb_q),
        .pb_req  (pb_req)
    );

    assign req = ~supply_q | wd_expire | pb_req;

    rstsup_pulse_gen #(.PULSE_TICKS(PULSE_TICKS)) u_pgen (
        .clk      (clk),
        .arst_n   (arst_n),
        .req      (req),
        .in_reset (in_reset)
    );

    always_comb begin
        rst_n = ~in_reset;
        rst   = in_reset;
    end

    // R2: a low synchronized supply forces reset on the next cycle
    assert_supply_low_resets_R2: assert property (@(posedge clk) disable iff (!arst_n)
        !supply_q |=> !rst_n);

    // R8: a confirmed button press forces reset on the next cycle
    assert_button_resets_R8: assert property (@(posedge clk) disable iff (!arst_n)
        pb_req |=> !rst_n);
endmodule

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
    localparam int P   = 40;
    localparam int PB  = 16;
    localparam int WS  = 50;
    localparam int WM  = 100;
    localparam int WL  = 200;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic wd_strobe = 1'b0;
    logic [1:0] wd_sel = 2'd0;
    logic pb_n = 1'b1;
    logic rst_n, rst;

    rst_supervisor #(.PULSE_TICKS(P), .PB_TICKS(PB), .WD_SHORT(WS),
                     .WD_MED(WM), .WD_LONG(WL)) u_dut (
        .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .wd_strobe(wd_strobe),
        .wd_sel(wd_sel), .pb_n(pb_n), .rst_n(rst_n), .rst(rst)
    );

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    due;
        bit    exp_n;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic expect_at(input int delay, input bit val, input string tag);
        exp_item_t it;
        it.due = cyc + delay;
        it.exp_n = val;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compares due items at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (rst_n !== it.exp_n) begin
                n_bad++;
                $display("FAIL %s cycle %0d: rst_n=%b expected %b", it.tag, cyc, rst_n, it.exp_n);
            end
            n_cmp++;
            if (rst !== ~it.exp_n) begin   // R9 complement
                n_bad++;
                $display("FAIL R9 cycle %0d: rst=%b expected %b", cyc, rst, ~it.exp_n);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // strobe service process
    bit svc_en = 1'b1;
    bit hold_lvl = 1'b0;
    int last_fall = 0;
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            #2;
            if (svc_en) begin
                ph++;
                if (ph == 10) begin
                    ph = 0;
                    if (wd_strobe) last_fall = cyc;
                    wd_strobe = ~wd_strobe;
                end
            end else if (wd_strobe != hold_lvl) begin
                if (wd_strobe) last_fall = cyc;
                wd_strobe = hold_lvl;
            end
        end
    end

    task automatic drain();
        while (sb_q.size() > 0) tick(1);
    endtask

    // starve the watchdog at a level and check timeout and repeat
    task automatic starve(input bit [1:0] sel, input int lim, input int shorter,
                          input bit lvl, input bit rep, input string tag);
        int f;
        wd_sel = sel;
        tick(30);
        hold_lvl = lvl;
        svc_en = 1'b0;
        tick(2);
        f = last_fall;
        if (shorter > 0) expect_at(f + shorter + 10 - cyc, 1'b1, "R6 not shorter period");
        expect_at(f + lim - 3 - cyc, 1'b1, tag);
        expect_at(f + lim + 10 - cyc, 1'b0, tag);
        if (rep) begin
            expect_at(f + 2*lim + P - cyc, 1'b1, "R5 released between pulses");
            expect_at(f + 2*lim + P + 14 - cyc, 1'b0, "R5 repeated pulse");
        end
        drain();
        svc_en = 1'b1;
        tick(lim + P + 60);
        expect_at(1, 1'b1, "R11 recovered after service");
        drain();
    endtask

    initial begin
        // R1 reset state
        expect_at(2, 1'b0, "R1 reset state");
        expect_at(4, 1'b0, "R1 reset state");
        tick(6);
        supply_ok = 1'b1;
        arst_n = 1'b1;
        // R3 power-up width
        expect_at(P - 5, 1'b0, "R3 power-up width");
        expect_at(P + 8, 1'b1, "R3 power-up release");
        drain();
        tick(100);
        expect_at(1, 1'b1, "R4 serviced watchdog quiet");
        expect_at(60, 1'b1, "R4 serviced watchdog quiet");
        drain();

        // R2 supply dip
        supply_ok = 1'b0;
        expect_at(4, 1'b0, "R2 supply low asserts");
        expect_at(29, 1'b0, "R2 held while supply low");
        tick(30);
        supply_ok = 1'b1;
        expect_at(P - 5, 1'b0, "R3 width after supply");
        expect_at(P + 8, 1'b1, "R3 release after supply");
        drain();
        tick(20);

        // R10 reload during running pulse
        supply_ok = 1'b0;
        tick(10);
        supply_ok = 1'b1;
        tick(20);
        supply_ok = 1'b0;
        tick(5);
        supply_ok = 1'b1;
        expect_at(P - 20 + 8, 1'b0, "R10 pulse reloaded");
        expect_at(P - 5, 1'b0, "R10 width from last request");
        expect_at(P + 8, 1'b1, "R10 release after reload");
        drain();
        tick(20);

        // R7 short press ignored
        pb_n = 1'b0;
        tick(PB / 2);
        pb_n = 1'b1;
        expect_at(1, 1'b1, "R7 short press ignored");
        expect_at(10, 1'b1, "R7 short press ignored");
        drain();
        pb_n = 1'b0;
        tick(PB - 3);
        pb_n = 1'b1;
        expect_at(3, 1'b1, "R7 near-limit press ignored");
        expect_at(12, 1'b1, "R7 near-limit press ignored");
        drain();

        // R8 long press
        pb_n = 1'b0;
        expect_at(PB + 7, 1'b0, "R8 long press asserts");
        expect_at(39, 1'b0, "R8 held while pressed");
        tick(40);
        pb_n = 1'b1;
        expect_at(P - 5, 1'b0, "R8 width after release");
        expect_at(P + 8, 1'b1, "R8 release");
        drain();
        tick(20);

        // R4 / R5 / R6 watchdog starvation
        starve(2'd0, WS, 0, 1'b0, 1'b1, "R4 strobe held low times out");
        starve(2'd0, WS, 0, 1'b1, 1'b1, "R4 strobe held high times out");
        starve(2'd1, WM, WS, 1'b0, 1'b0, "R6 select 1 medium period");
        starve(2'd2, WL, WM, 1'b1, 1'b0, "R6 select 2 long period");
        starve(2'd3, WL, WM, 1'b0, 1'b0, "R6 select 3 long period");

        done = 1'b1;
    end

    // watchdog for a hung run
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: run did not end (cycle %0d, expected < 20000)", cyc);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule